// File: doc/BRIEF.md
# Address-Window Instruction Memory

This block stands in the instruction-fetch path where a cache would normally sit. It holds a fixed on-chip word array that answers every fetch whose address lies inside one configured window. No tags are stored and nothing is ever evicted. Whether a fetch is served locally depends only on its address. A fetch inside the window is answered on the next clock with no stall. A fetch outside the window goes to an external bus port, and the core is held in a stall until that port acknowledges. The acknowledged word is then passed back to the core.

Firmware is placed in the array through a separate load port, one word per clock, at a word index inside the window. While a load is in progress, fetch requests are dropped. Addresses are physical, and no translation stage sits in front of the compare. The window base must be aligned to the array size, so the compare only looks at the address bits above the array's index field. The array size is a parameter. Small arrays of 4 KB or 8 KB work, and so do arrays of several hundred kilobytes.

The miss controller has two named states. `S_IDLE` accepts fetches. `S_MISS` waits for the bus acknowledge. It has three transitions:
- IDLE to MISS, taken when an accepted fetch falls outside the window.
- MISS to MISS, taken while `bus_ack` is low.
- MISS to IDLE, taken on `bus_ack`.

Top module: `fetch_window_ram`

## Requirements
- R1: A fetch with `fetch_req` high, `load_en` low and no stall, whose address lies inside the window, gives `fetch_valid` high on the next clock with the stored word on `fetch_rdata`. `fetch_stall` and `bus_req` stay low.
- R2: The window covers byte addresses from `WIN_BASE` to `WIN_BASE + MEM_WORDS*4 - 1`. The word index is address bits [IDX_W+1:2]. The first word and the last word of the window hit. The word just below the window, the first word past it, and an address that differs only in its top bit all miss.
- R3: An accepted fetch outside the window moves the controller to S_MISS on the next clock. In S_MISS, `bus_req` and `fetch_stall` are high and `bus_addr` equals the fetch address. All three hold unchanged until `bus_ack`.
- R4: `bus_ack` in S_MISS returns the controller to S_IDLE. On the following clock, `fetch_valid` is high with the captured `bus_rdata`, and `bus_req` and `fetch_stall` are low.
- R5: With `load_en` high, `load_data` is written to word `load_idx` on the clock edge. A later in-window fetch of that word returns the last value written.
- R6: A fetch presented while `load_en` is high is ignored. On the next clock there is no `fetch_valid` and no `bus_req`.
- R7: A fetch presented while `fetch_stall` is high is ignored. `bus_addr` keeps its value, and no extra `fetch_valid` appears.
- R8: After reset, `fetch_valid`, `fetch_stall` and `bus_req` are low.
- R9: `bus_ack` seen in S_IDLE is ignored and gives no `fetch_valid`. With `fetch_req` low, `fetch_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request from the core |
| fetch_addr | input | ADDR_W | Physical byte address of the fetch |
| fetch_valid | output | 1 | Instruction word valid, one clock after hit or ack |
| fetch_rdata | output | DATA_W | Returned instruction word |
| fetch_stall | output | 1 | Core must hold while a miss is outstanding |
| bus_req | output | 1 | External bus request for a miss |
| bus_addr | output | ADDR_W | Address of the outstanding miss |
| bus_ack | input | 1 | External bus acknowledge |
| bus_rdata | input | DATA_W | Word returned by the external bus |
| load_en | input | 1 | Load port write strobe |
| load_idx | input | IDX_W | Word index within the window |
| load_data | input | DATA_W | Word to store |

## Verification
The assertions assume two things about the core. It does not expect a fetch to be taken while `fetch_stall` or `load_en` is high. The external bus raises `bus_ack` only while `bus_req` is high, or else its acknowledge is treated as stray and dropped. The stimulus follows both rules in the table walk. It then breaks each rule deliberately in directed cases, by fetching during a load, fetching during a stall, and acknowledging in idle, and checks at the ports that nothing changes. The window base used in the bench is aligned to the array size, as the compare requires.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_MISS = 1'b1
    } miss_state_t;
endpackage

// File: rtl/fwr_window_decode.sv
module fwr_window_decode #(
    parameter int ADDR_W = 32,
    parameter int LOW_W  = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
    input  logic [ADDR_W-LOW_W-1:0] addr_hi,
    output logic                    in_win
);
    localparam logic [ADDR_W-LOW_W-1:0] BASE_HI = WIN_BASE[ADDR_W-1:LOW_W];

    // Base is size-aligned, so only the bits above the index field matter.
    assign in_win = (addr_hi == BASE_HI);
endmodule

// File: rtl/fwr_word_store.sv
module fwr_word_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= cells[rd_idx];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/fwr_miss_ctrl.sv
module fwr_miss_ctrl
    import fwr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              stall,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data
);
    miss_state_t state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start)   state_d = S_MISS;
            S_MISS: if (bus_ack) state_d = S_IDLE;
            default:             state_d = S_IDLE;
        endcase
    end

    // State register plus latched miss address and response word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            addr_q     <= '0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            state_q    <= state_d;
            resp_valid <= (state_q == S_MISS) && bus_ack;
            if (state_q == S_IDLE && start) begin
                addr_q <= start_addr;
            end
            if (state_q == S_MISS && bus_ack) begin
                resp_data <= bus_rdata;
            end
        end
    end

    // Outputs from state.
    always_comb begin
        bus_req  = 1'b0;
        stall    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                bus_req = 1'b0;
                stall   = 1'b0;
            end
            S_MISS: begin
                bus_req = 1'b1;
                stall   = 1'b1;
            end
            default: begin
                bus_req = 1'b0;
                stall   = 1'b0;
            end
        endcase
    end
    assign bus_addr = addr_q;

    AST_MISS_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && start) |=> (bus_req && stall && bus_addr == $past(start_addr))); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr))); // R3
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (resp_valid && !bus_req && !stall)); // R4
    AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && bus_ack) |=> !resp_valid); // R9
endmodule

// File: rtl/fetch_window_ram.sv
module fetch_window_ram #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 1024,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000,
    localparam int IDX_W    = $clog2(MEM_WORDS),
    localparam int OFF_W    = $clog2(DATA_W / 8),
    localparam int LOW_W    = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_rdata,
    output logic              fetch_stall,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [DATA_W-1:0] load_data
);
    logic              in_win;
    logic              accept;
    logic              hit_go;
    logic              miss_go;
    logic              hit_q;
    logic [DATA_W-1:0] store_word;
    logic              miss_valid;
    logic [DATA_W-1:0] miss_word;

    fwr_window_decode #(
        .ADDR_W  (ADDR_W),
        .LOW_W   (LOW_W),
        .WIN_BASE(WIN_BASE)
    ) u_decode (
        .addr_hi(fetch_addr[ADDR_W-1:LOW_W]),
        .in_win (in_win)
    );

    assign accept  = fetch_req && !load_en && !fetch_stall;
    assign hit_go  = accept && in_win;
    assign miss_go = accept && !in_win;

    fwr_word_store #(
        .DATA_W(DATA_W),
        .DEPTH (MEM_WORDS)
    ) u_store (
        .clk    (clk),
        .wr_en  (load_en),
        .wr_idx (load_idx),
        .wr_data(load_data),
        .rd_en  (hit_go),
        .rd_idx (fetch_addr[OFF_W +: IDX_W]),
        .rd_data(store_word)
    );

    fwr_miss_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_miss (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (miss_go),
        .start_addr(fetch_addr),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .stall     (fetch_stall),
        .resp_valid(miss_valid),
        .resp_data (miss_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit_go;
        end
    end

    assign fetch_valid = hit_q || miss_valid;
    assign fetch_rdata = hit_q ? store_word : miss_word;

    AST_HIT_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !load_en && !fetch_stall && in_win) |=> (fetch_valid && !fetch_stall && !bus_req)); // R1
    AST_LOAD_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !fetch_stall) |=> (!fetch_valid && !bus_req)); // R6
    AST_STALL_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall == bus_req); // R3
    AST_VALID_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hit_q, miss_valid}) <= 1); // R4
endmodule

// File: tb/fetch_window_ram_tb.sv
module fetch_window_ram_tb_top;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int WORDS  = 64;
    localparam int IDX_W  = $clog2(WORDS);
    localparam logic [31:0] BASE = 32'h0000_2000;
    localparam int NVEC = 8;

    localparam logic [31:0] VEC_ADDR [NVEC] = '{
        32'h0000_2000, 32'h0000_20FC, 32'h0000_2044, 32'h0000_1FFC,
        32'h0000_2100, 32'h8000_2000, 32'h0000_2080, 32'h0000_0000
    };
    localparam bit VEC_HIT [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_req = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic fetch_valid;
    logic [DATA_W-1:0] fetch_rdata;
    logic fetch_stall;
    logic bus_req;
    logic [ADDR_W-1:0] bus_addr;
    logic bus_ack = 1'b0;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic load_en = 1'b0;
    logic [IDX_W-1:0] load_idx = '0;
    logic [DATA_W-1:0] load_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    fetch_window_ram #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_WORDS(WORDS), .WIN_BASE(BASE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_rdata(fetch_rdata), .fetch_stall(fetch_stall),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .load_en(load_en), .load_idx(load_idx), .load_data(load_data)
    );

    function automatic logic [31:0] pat(int i);
        return 32'hC0DE_0000 + 32'(i) * 32'h0001_0011;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue a single fetch and follow it to completion.
    task automatic do_fetch(input logic [31:0] a, input bit hit, input logic [31:0] exp_word, input string req);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_req = 1'b0;
        if (hit) begin
            chk(fetch_valid === 1'b1 && fetch_stall === 1'b0 && bus_req === 1'b0, {req, " hit no stall"},
                {29'd0, fetch_valid, fetch_stall, bus_req}, 32'd4);
            chk(fetch_rdata === exp_word, {req, " hit word"}, fetch_rdata, exp_word);
        end else begin
            chk(bus_req === 1'b1 && fetch_stall === 1'b1 && fetch_valid === 1'b0, {req, " R3 miss request"},
                {29'd0, fetch_valid, fetch_stall, bus_req}, 32'd3);
            chk(bus_addr === a, {req, " R3 miss address"}, bus_addr, a);
            @(negedge clk);
            @(negedge clk);
            chk(bus_req === 1'b1 && fetch_stall === 1'b1 && bus_addr === a, {req, " R3 held"}, bus_addr, a);
            bus_ack = 1'b1; bus_rdata = ~a;
            @(negedge clk);
            bus_ack = 1'b0;
            chk(fetch_valid === 1'b1 && fetch_rdata === ~a, {req, " R4 word"}, fetch_rdata, ~a);
            chk(bus_req === 1'b0 && fetch_stall === 1'b0, {req, " R4 release"},
                {30'd0, fetch_stall, bus_req}, 32'd0);
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected below 100000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(fetch_valid === 1'b0 && fetch_stall === 1'b0 && bus_req === 1'b0, "R8 reset",
            {29'd0, fetch_valid, fetch_stall, bus_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fetch_valid === 1'b0 && fetch_stall === 1'b0 && bus_req === 1'b0, "R8 after reset",
            {29'd0, fetch_valid, fetch_stall, bus_req}, 32'd0);

        // R5 fill the array
        for (int i = 0; i < WORDS; i++) begin
            load_en = 1'b1; load_idx = IDX_W'(i); load_data = pat(i);
            @(negedge clk);
        end
        load_en = 1'b0;

        // Table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            do_fetch(VEC_ADDR[v], VEC_HIT[v], pat(int'(VEC_ADDR[v][7:2])),
                     VEC_HIT[v] ? "R1 R2 R5" : "R2");
        end

        // R6: fetch during load is ignored, out-of-window address would miss
        @(negedge clk);
        load_en = 1'b1; load_idx = 6'd5; load_data = 32'h1234_5678;
        fetch_req = 1'b1; fetch_addr = 32'h0000_4000;
        @(negedge clk);
        load_en = 1'b0; fetch_req = 1'b0;
        chk(fetch_valid === 1'b0 && bus_req === 1'b0, "R6 fetch during load",
            {30'd0, fetch_valid, bus_req}, 32'd0);
        do_fetch(BASE + 32'h14, 1'b1, 32'h1234_5678, "R5 overwrite");

        // R7: fetch during stall is ignored
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 32'h0000_3000;
        @(negedge clk);
        fetch_addr = BASE + 32'h8;
        @(negedge clk);
        fetch_req = 1'b0;
        chk(fetch_valid === 1'b0 && bus_addr === 32'h0000_3000, "R7 fetch while stalled",
            bus_addr, 32'h0000_3000);
        bus_ack = 1'b1; bus_rdata = 32'hFACE_0001;
        @(negedge clk);
        bus_ack = 1'b0;
        chk(fetch_valid === 1'b1 && fetch_rdata === 32'hFACE_0001, "R7 miss completes", fetch_rdata, 32'hFACE_0001);
        @(negedge clk);
        chk(fetch_valid === 1'b0, "R7 no extra valid", {31'd0, fetch_valid}, 32'd0);

        // R9: stray ack in idle, and idle with no request
        bus_ack = 1'b1; bus_rdata = 32'hDEAD_BEEF;
        @(negedge clk);
        bus_ack = 1'b0;
        chk(fetch_valid === 1'b0 && bus_req === 1'b0, "R9 stray ack", {30'd0, fetch_valid, bus_req}, 32'd0);
        @(negedge clk);
        chk(fetch_valid === 1'b0, "R9 no request", {31'd0, fetch_valid}, 32'd0);

        // R1 back-to-back hits
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = BASE + 32'hF8;
        @(negedge clk);
        fetch_addr = BASE + 32'h4;
        chk(fetch_valid === 1'b1 && fetch_rdata === pat(62), "R1 back-to-back first", fetch_rdata, pat(62));
        @(negedge clk);
        fetch_req = 1'b0;
        chk(fetch_valid === 1'b1 && fetch_rdata === pat(1), "R1 back-to-back second", fetch_rdata, pat(1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule